// File: doc/BRIEF.md
# Compare-Channel Real-Time Counter Interrupt Unit

This block keeps a free-running real-time counter and watches it with three compare channels. Each channel holds a compare value, an enable bit and a routing word. The routing word carries an interrupt vector index and a target processor ID, which the block drives out as fields. A channel that is enabled raises a sticky pending flag once the counter has reached its compare value. Its interrupt request line is high while that flag and its enable are both set.

All pending flags share one event-status word. Each channel sits at a base bit shifted left by its index. Bit 0 is kept for a reserved lower channel that this unit does not expose. The status word itself is read-only. Software clears flags by writing a mask to a separate clear address. Before a channel is re-armed, software should:

1. disable it;
2. park its compare value at all-ones, a value the counter never reaches;
3. clear its flag;
4. write its routing word;
5. enable it;
6. write the real compare value.

Each channel runs a four-state machine:

- `CH_IDLE`: disabled, nothing pending.
- `CH_WATCH`: enabled and waiting for the counter.
- `CH_HELD`: enabled and pending. The request line is high.
- `CH_LATCHED`: pending but disabled.

Transitions follow the next values of the enable and pending bits:

- **arm**: IDLE to WATCH.
- **fire**: WATCH to HELD.
- **mask**: HELD to LATCHED.
- **unmask**: LATCHED to HELD.
- **ack**: HELD to WATCH, or LATCHED to IDLE.
- **disarm**: WATCH to IDLE.

Top module: `rtc_cmp_irq`

## Requirements
- R1: The counter is 55 bits wide. It is 0 in reset and adds 1 on every clock. A read of word 0 returns the value held in the cycle of the request, zero-extended to 64 bits. Writes to word 0 are ignored.
- R2: Channel i keeps its compare value at word 4+i. This value resets to all-ones and reads back as written. An enabled channel whose compare value is all-ones never becomes pending.
- R3: An enabled channel becomes pending when the counter is greater than or equal to its compare value. The pending flag and the request line are first seen in the cycle after the counter equals the compare value.
- R4: The pending flag of channel i reads as bit 1+i of word 1. Every other bit of word 1 reads 0. A pending flag stays set while the channel is disabled.
- R5: Writing a mask to word 2 clears exactly those pending flags whose bits are set in the mask and leaves the others. Word 2 reads 0. Writes to word 1 have no effect.
- R6: A clear takes no hold while the channel is enabled and the counter is still at or past its compare value: the flag is set again on the same edge. After the arming order is followed, the channel reads not pending and its request line is low.
- R7: Channel i keeps its enable as bit 0 of word 8+i, and that bit reads back. The request line of channel i is high exactly when the channel is both pending and enabled.
- R8: Channel i keeps its routing word at word 12+i. The vector index sits in bits 7:0 and the processor ID in bits 31:16. These drive `ch_vector[8i+7:8i]` and `ch_target[16i+15:16i]`. Other bits read back 0.
- R9: Read data and `bus_rvalid` appear in the cycle after the read request. An address with no register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| irq | output | 3 | Interrupt request, one bit per channel |
| ch_vector | output | 24 | Vector index of each channel, 8 bits each |
| ch_target | output | 48 | Processor ID of each channel, 16 bits each |

## Verification
The hardest case to reach is the refire: a clear written while the channel is still enabled and already past its compare value. The flag never visibly drops there, so the stimulus parks the compare value at zero to hold the match. It then shows both the failed clear and the recovery through the full arming order. The exact firing cycle is checked against a bench-side copy of the counter. A compare value is placed a fixed distance ahead of that copy, and the bench checks the copy's value when the request line rises.

// File: rtl/rtc_cmp_pkg.sv
package rtc_cmp_pkg;
    localparam int WORD_W  = 64;
    localparam int VEC_W   = 8;
    localparam int VEC_LSB = 0;
    localparam int PID_W   = 16;
    localparam int PID_LSB = 16;

    // word addresses; channel blocks are four words apart
    localparam int A_COUNT    = 0;
    localparam int A_EVENT    = 1;
    localparam int A_EVCLR    = 2;
    localparam int A_CMP_BASE = 4;
    localparam int A_ENA_BASE = 8;
    localparam int A_CFG_BASE = 12;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_WATCH,
        CH_HELD,
        CH_LATCHED
    } ch_state_e;
endpackage

// File: rtl/rtc_free_counter.sv
module rtc_free_counter #(
    parameter int CNT_W = 55
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) count <= '0;
        else        count <= count + 1'b1;
    end

    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> count == CNT_W'($past(count) + 1'b1));
endmodule

// File: rtl/rtc_cmp_channel.sv
module rtc_cmp_channel
    import rtc_cmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] now_val,
    input  logic              wr_cmp,
    input  logic              wr_ena,
    input  logic              wr_cfg,
    input  logic [WORD_W-1:0] wdata,
    input  logic              clr_hit,
    output logic [WORD_W-1:0] cmp_q,
    output logic              en,
    output logic              pend,
    output logic              irq,
    output logic [VEC_W-1:0]  vec_q,
    output logic [PID_W-1:0]  pid_q
);
    ch_state_e state_q, state_d;
    logic      hit, nxt_en, nxt_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '1;
            vec_q <= '0;
            pid_q <= '0;
        end else begin
            if (wr_cmp) cmp_q <= wdata;
            if (wr_cfg) begin
                vec_q <= wdata[VEC_LSB +: VEC_W];
                pid_q <= wdata[PID_LSB +: PID_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // next state: arm, fire, mask, unmask, ack, disarm
    always_comb begin
        hit      = (now_val >= cmp_q);
        nxt_pend = (pend & ~clr_hit) | (en & hit);
        nxt_en   = wr_ena ? wdata[0] : en;
        unique case ({nxt_en, nxt_pend})
            2'b00:   state_d = CH_IDLE;
            2'b10:   state_d = CH_WATCH;
            2'b11:   state_d = CH_HELD;
            default: state_d = CH_LATCHED;
        endcase
    end

    always_comb begin
        unique case (state_q)
            CH_IDLE:    begin en = 1'b0; pend = 1'b0; irq = 1'b0; end
            CH_WATCH:   begin en = 1'b1; pend = 1'b0; irq = 1'b0; end
            CH_HELD:    begin en = 1'b1; pend = 1'b1; irq = 1'b1; end
            default:    begin en = 1'b0; pend = 1'b1; irq = 1'b0; end
        endcase
    end

    assert_set_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend) |-> $past(en));
    assert_sticky_pending_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !clr_hit) |=> pend);
    assert_parked_never_fires_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend && cmp_q == '1) |=> !pend);
    assert_clear_refires_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wr_ena && clr_hit && now_val >= cmp_q) |=> pend);
endmodule

// File: rtl/rtc_bus_port.sv
module rtc_bus_port
    import rtc_cmp_pkg::*;
#(
    parameter int NCH    = 3,
    parameter int ADDR_W = 6
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [WORD_W-1:0]     count_ext,
    input  logic [WORD_W-1:0]     status_w,
    input  logic [NCH*WORD_W-1:0] cmp_flat,
    input  logic [NCH-1:0]        en_vec,
    input  logic [NCH*WORD_W-1:0] cfg_flat,
    output logic [NCH-1:0]        wr_cmp,
    output logic [NCH-1:0]        wr_ena,
    output logic [NCH-1:0]        wr_cfg,
    output logic                  clr_wr,
    output logic [WORD_W-1:0]     rdata,
    output logic                  rvalid
);
    logic [WORD_W-1:0] rd_mux;

    assign clr_wr = bus_wr && (bus_addr == ADDR_W'(A_EVCLR));

    for (genvar i = 0; i < NCH; i++) begin : g_dec
        assign wr_cmp[i] = bus_wr && (bus_addr == ADDR_W'(A_CMP_BASE + i));
        assign wr_ena[i] = bus_wr && (bus_addr == ADDR_W'(A_ENA_BASE + i));
        assign wr_cfg[i] = bus_wr && (bus_addr == ADDR_W'(A_CFG_BASE + i));
    end

    always_comb begin
        rd_mux = '0;
        if (bus_addr == ADDR_W'(A_COUNT)) rd_mux = count_ext;
        if (bus_addr == ADDR_W'(A_EVENT)) rd_mux = status_w;
        for (int i = 0; i < NCH; i++) begin
            if (bus_addr == ADDR_W'(A_CMP_BASE + i)) rd_mux = cmp_flat[i*WORD_W +: WORD_W];
            if (bus_addr == ADDR_W'(A_ENA_BASE + i)) rd_mux = WORD_W'(en_vec[i]);
            if (bus_addr == ADDR_W'(A_CFG_BASE + i)) rd_mux = cfg_flat[i*WORD_W +: WORD_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= bus_rd;
            if (bus_rd) rdata <= rd_mux;
        end
    end

    assert_read_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> rvalid);
endmodule

// File: rtl/rtc_cmp_irq.sv
module rtc_cmp_irq
    import rtc_cmp_pkg::*;
#(
    parameter int CNT_W    = 55,
    parameter int NCH      = 3,
    parameter int ADDR_W   = 6,
    parameter int EVT_BASE = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [63:0]          bus_wdata,
    output logic [63:0]          bus_rdata,
    output logic                 bus_rvalid,
    output logic [NCH-1:0]       irq,
    output logic [NCH*8-1:0]     ch_vector,
    output logic [NCH*16-1:0]    ch_target
);
    logic [CNT_W-1:0]      count;
    logic [WORD_W-1:0]     count_ext, status_w;
    logic [NCH*WORD_W-1:0] cmp_flat, cfg_flat;
    logic [NCH-1:0]        en_vec, pend_vec, wr_cmp, wr_ena, wr_cfg, clr_hit;
    logic                  clr_wr;

    rtc_free_counter #(.CNT_W(CNT_W)) i_count (
        .clk(clk), .rst_n(rst_n), .count(count)
    );

    assign count_ext = WORD_W'(count);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic [VEC_W-1:0] vec_q;
        logic [PID_W-1:0] pid_q;

        assign clr_hit[i] = clr_wr & bus_wdata[EVT_BASE + i];

        rtc_cmp_channel i_ch (
            .clk(clk), .rst_n(rst_n), .now_val(count_ext),
            .wr_cmp(wr_cmp[i]), .wr_ena(wr_ena[i]), .wr_cfg(wr_cfg[i]),
            .wdata(bus_wdata), .clr_hit(clr_hit[i]),
            .cmp_q(cmp_flat[i*WORD_W +: WORD_W]), .en(en_vec[i]),
            .pend(pend_vec[i]), .irq(irq[i]), .vec_q(vec_q), .pid_q(pid_q)
        );

        assign ch_vector[i*VEC_W +: VEC_W] = vec_q;
        assign ch_target[i*PID_W +: PID_W] = pid_q;
        assign cfg_flat[i*WORD_W +: WORD_W] =
            (WORD_W'(pid_q) << PID_LSB) | (WORD_W'(vec_q) << VEC_LSB);
    end

    always_comb begin
        status_w = '0;
        for (int i = 0; i < NCH; i++) status_w[EVT_BASE + i] = pend_vec[i];
    end

    rtc_bus_port #(.NCH(NCH), .ADDR_W(ADDR_W)) i_bus (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .count_ext(count_ext), .status_w(status_w),
        .cmp_flat(cmp_flat), .en_vec(en_vec), .cfg_flat(cfg_flat),
        .wr_cmp(wr_cmp), .wr_ena(wr_ena), .wr_cfg(wr_cfg), .clr_wr(clr_wr),
        .rdata(bus_rdata), .rvalid(bus_rvalid)
    );
endmodule

// File: tb/test_rtc_cmp_irq.sv
module test_rtc_cmp_irq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic        bus_rvalid;
    logic [2:0]  irq;
    logic [23:0] ch_vector;
    logic [47:0] ch_target;

    int          checks = 0, errors = 0;
    bit          done = 1'b0;
    logic [63:0] tb_cnt;
    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    rtc_cmp_irq i_rtc_cmp_irq (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .irq(irq), .ch_vector(ch_vector), .ch_target(ch_target)
    );

    // model of the counter from R1
    always @(posedge clk or negedge rst_n)
        if (!rst_n) tb_cnt <= '0;
        else        tb_cnt <= tb_cnt + 64'd1;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [5:0] a, input logic [63:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic read_reg(input logic [5:0] a, input logic [63:0] exp, input string req);
        exp_q.push_back(exp); tag_q.push_back(req);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_irq(input int ch, input logic [63:0] exp_cnt, input string req);
        bit seen = 1'b0;
        for (int k = 0; k < 300 && !seen; k++) begin
            if (irq[ch]) seen = 1'b1;
            else @(negedge clk);
        end
        check(seen && tb_cnt == exp_cnt, req, tb_cnt, exp_cnt);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (bus_rvalid) begin
            if (exp_q.size() == 0) check(1'b0, "R9 unexpected rvalid", bus_rdata, 64'd0);
            else begin
                logic [63:0] e;
                string       t;
                e = exp_q.pop_front(); t = tag_q.pop_front();
                check(bus_rdata === e, t, bus_rdata, e);
            end
        end
    end

    initial begin
        logic [63:0] c;
        repeat (3) @(negedge clk);
        check(irq === 3'b000 && bus_rvalid === 1'b0, "R9 reset outputs", {60'd0, bus_rvalid, irq}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        read_reg(6'd1, 64'd0, "R4 status after reset");
        read_reg(6'd4, '1, "R2 compare reset all-ones");
        read_reg(6'd8, 64'd0, "R7 enable after reset");
        read_reg(6'd63, 64'd0, "R9 unmapped reads zero");
        read_reg(6'd0, tb_cnt, "R1 counter read");
        write_reg(6'd0, 64'd5);
        read_reg(6'd0, tb_cnt, "R1 counter write ignored");
        // routing word of channel 1
        write_reg(6'd13, 64'hDEAD_BEEF_1234_7FA5);
        read_reg(6'd13, 64'h0000_0000_1234_00A5, "R8 config readback");
        check(ch_vector[15:8] == 8'hA5, "R8 vector field", 64'(ch_vector[15:8]), 64'hA5);
        check(ch_target[31:16] == 16'h1234, "R8 target field", 64'(ch_target[31:16]), 64'h1234);
        // parked compare never fires
        write_reg(6'd8, 64'd1);
        read_reg(6'd8, 64'd1, "R7 enable readback");
        repeat (40) @(negedge clk);
        check(irq[0] == 1'b0, "R2 parked channel silent", 64'(irq[0]), 64'd0);
        // exact fire cycle on channel 0
        c = tb_cnt + 64'd20;
        write_reg(6'd4, c);
        read_reg(6'd4, c, "R2 compare readback");
        wait_irq(0, c + 64'd1, "R3 fire cycle ch0");
        read_reg(6'd1, 64'h2, "R4 status bit 1 for ch0");
        write_reg(6'd8, 64'd0);
        check(irq[0] == 1'b0, "R7 disable drops irq", 64'(irq[0]), 64'd0);
        read_reg(6'd1, 64'h2, "R4 pending kept while disabled");
        write_reg(6'd2, 64'h4);
        read_reg(6'd1, 64'h2, "R5 clear of other bit leaves ch0");
        write_reg(6'd1, '1);
        read_reg(6'd1, 64'h2, "R5 status write ignored");
        read_reg(6'd2, 64'd0, "R5 alias reads zero");
        write_reg(6'd2, 64'h2);
        read_reg(6'd1, 64'd0, "R5 clear ch0");
        // refire on channel 2
        write_reg(6'd10, 64'd1);
        write_reg(6'd6, 64'd0);
        @(negedge clk);
        check(irq[2] == 1'b1, "R3 passed compare fires ch2", 64'(irq[2]), 64'd1);
        write_reg(6'd2, 64'h8);
        check(irq[2] == 1'b1, "R6 clear refires", 64'(irq[2]), 64'd1);
        read_reg(6'd1, 64'h8, "R6 status still pending");
        write_reg(6'd10, 64'd0);
        write_reg(6'd6, '1);
        write_reg(6'd2, 64'h8);
        write_reg(6'd10, 64'd1);
        read_reg(6'd1, 64'd0, "R6 arming order clears");
        check(irq[2] == 1'b0, "R6 irq low after arming", 64'(irq[2]), 64'd0);
        c = tb_cnt + 64'd10;
        write_reg(6'd6, c);
        wait_irq(2, c + 64'd1, "R3 fire cycle ch2");
        // channel 1 alongside channel 2
        write_reg(6'd9, 64'd1);
        c = tb_cnt + 64'd5;
        write_reg(6'd5, c);
        wait_irq(1, c + 64'd1, "R3 fire cycle ch1");
        read_reg(6'd1, 64'hC, "R4 two channels pending");
        write_reg(6'd5, '1);
        write_reg(6'd2, 64'h4);
        read_reg(6'd1, 64'h8, "R5 clear exactly ch1");
        check(irq == 3'b100, "R7 irq follows pending and enable", 64'(irq), 64'h4);
        repeat (2) @(negedge clk);
        check(exp_q.size() == 0, "R9 all reads answered", 64'(exp_q.size()), 64'd0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule